// File: doc/BRIEF.md
# Pulse-Position Infrared Command Transmitter

This block turns one remote-control command into the gated infrared drive for an emitter. On a start strobe it latches a 16-bit address and an 8-bit command, waits a fixed holdoff, then sends a framed 32-bit code. Each bit is sent as a fixed carrier burst, and the length of the silence after it tells 0 from 1. The frame carries the address low byte, the address high byte, the command, and the command inverted inside the block. Every burst is gated by a carrier of one twelfth of the tick rate, high for a third of each carrier period.

While the key-held input stays high, a new code starts on a fixed period grid measured from the start of the first code. The repeat style is chosen at the strobe. In one-shot style every later code is a short header-plus-stop marker. In full style the whole frame is sent again. An active-low lamp output is low exactly while a code is on the air. A one-cycle done pulse marks the return to idle, which happens only at a code boundary.

All timing is counted in units of `UNIT_TICKS` tick-enables. The default of 256 ticks at a 455 kHz tick gives units of about 0.5626 ms. Every interval below is given in units.

Top module: `ir_frame_tx`

## Requirements
- R1: A full frame sends 32 data bits, LSB first, as the word {~cmd, cmd, addr[15:8], addr[7:0]}: bit 0 of addr goes first, and the last data bit is bit 7 of the inverted command. A single stop burst follows.
- R2: Each data bit is a 1-unit burst. A 0 bit starts the next burst 2 units after its own start, and a 1 bit after 4 units. The stop burst lasts 1 unit.
- R3: Every code opens with a 16-unit burst. In a full frame, 8 silent units follow before the first data burst.
- R4: Inside a burst the output is a carrier that repeats every 12 ticks and is high for 4 of them. Each burst begins with the high part of the carrier. Outside bursts the output is 0.
- R5: The first code starts 64 units after the strobe is accepted. It is a full frame, and it is sent completely even if the key is released during the holdoff.
- R6: While key_held is high, each further code starts exactly 192 units after the start of the previous code.
- R7: In one-shot style (repeat_full=0), each code after the first is a 16-unit burst, 4 silent units, then a 1-unit stop burst.
- R8: In full style (repeat_full=1), each code after the first is the complete frame of R1 to R3.
- R9: lamp_n is low from the first tick of a code's opening burst to the end of its stop burst. It is high during the holdoff, between codes and when idle.
- R10: If key_held is low at the end of a code, or at the next period boundary, the block goes idle. It pulses done high for exactly one clock on that return.
- R11: addr, cmd and repeat_full are sampled only when a strobe is accepted in idle. A strobe at any other time is ignored, and later changes on those inputs have no effect.
- R12: Every interval advances only on clocks where tick is high. The outputs change only on such clocks, apart from the fall of the done pulse.
- R13: After reset, ir_out is 0, lamp_n is 1 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable at the oscillator rate |
| start | input | 1 | Start strobe, accepted only when idle |
| key_held | input | 1 | High while the key stays pressed |
| repeat_full | input | 1 | 1: resend the full frame; 0: send the short repeat marker |
| addr | input | 16 | Address (custom) code |
| cmd | input | 8 | Command byte |
| ir_out | output | 1 | Carrier-gated emitter drive |
| lamp_n | output | 1 | Low while a code is emitted |
| done | output | 1 | One-clock pulse on return to idle |

## Verification
Some properties are checked on every cycle. The carrier never stays high for more than four ticks. Carrier only appears while the lamp is low. Done is a single cycle and happens only with the lamp high and the output silent. The outputs stay put on clocks without a tick. Other behaviour can only be shown by the bench's scenarios, which decode the output back into burst start times counted in ticks. These cover the exact bit order and spacing, the holdoff, the period grid, the difference between the two repeat styles, and the total lamp-low time. They also cover the release decision at code end versus period end, and that a second strobe or changed inputs after acceptance have no effect.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DELAY,
      ST_LEAD_ON,
      ST_LEAD_OFF,
      ST_BIT_ON,
      ST_BIT_OFF,
      ST_STOP_ON,
      ST_GAP
   } tx_state_t;

   function automatic logic state_bursting(tx_state_t s);
      return (s == ST_LEAD_ON) || (s == ST_BIT_ON) || (s == ST_STOP_ON);
   endfunction

   function automatic logic state_in_code(tx_state_t s);
      return (s == ST_LEAD_ON) || (s == ST_LEAD_OFF) || (s == ST_BIT_ON) ||
             (s == ST_BIT_OFF) || (s == ST_STOP_ON);
   endfunction
endpackage

// File: rtl/ir_tx_timebase.sv
module ir_tx_timebase #(
   parameter int UNIT_TICKS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   output logic unit_end
);
   localparam int CW = $clog2(UNIT_TICKS);
   localparam logic [CW-1:0] LAST = CW'(UNIT_TICKS - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign unit_end = tick && !restart && (cnt == LAST);
endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier #(
   parameter int CARRIER_DIV  = 12,
   parameter int CARRIER_HIGH = 4,
   parameter bit MODULATE     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic burst,
   output logic ir_out
);
   generate
      if (MODULATE) begin : g_mod
         localparam int CW = $clog2(CARRIER_DIV);
         logic [CW-1:0] phase;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase <= '0;
            end else if (!burst) begin
               phase <= '0;
            end else if (tick) begin
               phase <= (phase == CW'(CARRIER_DIV - 1)) ? '0 : phase + 1'b1;
            end
         end

         assign ir_out = burst && (phase < CW'(CARRIER_HIGH));
      end else begin : g_env
         assign ir_out = burst;
      end
   endgenerate
endmodule

// File: rtl/ir_tx_sequencer.sv
module ir_tx_sequencer
   import ir_tx_pkg::*;
#(
   parameter int ADDR_W           = 16,
   parameter int CMD_W            = 8,
   parameter int START_UNITS      = 64,
   parameter int PERIOD_UNITS     = 192,
   parameter int LEAD_ON_UNITS    = 16,
   parameter int LEAD_OFF_UNITS   = 8,
   parameter int REP_OFF_UNITS    = 4,
   parameter int MARK_UNITS       = 1,
   parameter int ZERO_SPACE_UNITS = 1,
   parameter int ONE_SPACE_UNITS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              key_held,
   input  logic              repeat_full,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CMD_W-1:0]  cmd,
   input  logic              unit_end,
   output logic              restart,
   output logic              code_active,
   output logic              burst,
   output logic              done
);
   localparam int FRAME_BITS = ADDR_W + 2 * CMD_W;
   localparam int BW = $clog2(FRAME_BITS);
   localparam int M1 = (START_UNITS > LEAD_ON_UNITS) ? START_UNITS : LEAD_ON_UNITS;
   localparam int M2 = (M1 > LEAD_OFF_UNITS) ? M1 : LEAD_OFF_UNITS;
   localparam int M3 = (M2 > REP_OFF_UNITS) ? M2 : REP_OFF_UNITS;
   localparam int M4 = (M3 > ONE_SPACE_UNITS) ? M3 : ONE_SPACE_UNITS;
   localparam int M5 = (M4 > ZERO_SPACE_UNITS) ? M4 : ZERO_SPACE_UNITS;
   localparam int SEG_MAX = (M5 > MARK_UNITS) ? M5 : MARK_UNITS;
   localparam int SEGW = $clog2(SEG_MAX + 1);
   localparam int PW = $clog2(PERIOD_UNITS + 1);

   tx_state_t             state;
   logic [SEGW-1:0]       seg_left;
   logic [PW-1:0]         per_cnt;
   logic [FRAME_BITS-1:0] frame_q;
   logic [FRAME_BITS-1:0] shreg;
   logic [BW-1:0]         bit_idx;
   logic                  rep_q;
   logic                  full_q;
   logic                  done_q;
   logic                  seg_last;
   logic                  period_last;

   assign restart     = (state == ST_IDLE) && start;
   assign code_active = state_in_code(state);
   assign burst       = state_bursting(state);
   assign done        = done_q;
   assign seg_last    = (seg_left == SEGW'(1));
   assign period_last = (per_cnt == PW'(PERIOD_UNITS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         seg_left <= '0;
         per_cnt  <= '0;
         frame_q  <= '0;
         shreg    <= '0;
         bit_idx  <= '0;
         rep_q    <= 1'b0;
         full_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (unit_end && (state != ST_IDLE)) begin
            per_cnt  <= per_cnt + 1'b1;
            seg_left <= seg_left - 1'b1;
         end
         case (state)
            ST_IDLE: begin
               if (start) begin
                  frame_q  <= {~cmd, cmd, addr};
                  full_q   <= repeat_full;
                  seg_left <= SEGW'(START_UNITS);
                  state    <= ST_DELAY;
               end
            end
            ST_DELAY: begin
               if (unit_end && seg_last) begin
                  state    <= ST_LEAD_ON;
                  seg_left <= SEGW'(LEAD_ON_UNITS);
                  per_cnt  <= '0;
                  rep_q    <= 1'b0;
                  shreg    <= frame_q;
                  bit_idx  <= '0;
               end
            end
            ST_LEAD_ON: begin
               if (unit_end && seg_last) begin
                  state    <= ST_LEAD_OFF;
                  seg_left <= rep_q ? SEGW'(REP_OFF_UNITS) : SEGW'(LEAD_OFF_UNITS);
               end
            end
            ST_LEAD_OFF: begin
               if (unit_end && seg_last) begin
                  state    <= rep_q ? ST_STOP_ON : ST_BIT_ON;
                  seg_left <= SEGW'(MARK_UNITS);
               end
            end
            ST_BIT_ON: begin
               if (unit_end && seg_last) begin
                  state    <= ST_BIT_OFF;
                  seg_left <= shreg[0] ? SEGW'(ONE_SPACE_UNITS) : SEGW'(ZERO_SPACE_UNITS);
               end
            end
            ST_BIT_OFF: begin
               if (unit_end && seg_last) begin
                  shreg    <= shreg >> 1;
                  seg_left <= SEGW'(MARK_UNITS);
                  if (bit_idx == BW'(FRAME_BITS - 1)) begin
                     state <= ST_STOP_ON;
                  end else begin
                     state   <= ST_BIT_ON;
                     bit_idx <= bit_idx + 1'b1;
                  end
               end
            end
            ST_STOP_ON: begin
               if (unit_end && seg_last) begin
                  if (key_held) begin
                     state <= ST_GAP;
                  end else begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (unit_end && period_last) begin
                  if (key_held) begin
                     state    <= ST_LEAD_ON;
                     seg_left <= SEGW'(LEAD_ON_UNITS);
                     per_cnt  <= '0;
                     rep_q    <= !full_q;
                     shreg    <= frame_q;
                     bit_idx  <= '0;
                  end else begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ir_frame_tx.sv
module ir_frame_tx #(
   parameter int UNIT_TICKS       = 256,
   parameter int CARRIER_DIV      = 12,
   parameter int CARRIER_HIGH     = 4,
   parameter bit MODULATE         = 1'b1,
   parameter int ADDR_W           = 16,
   parameter int CMD_W            = 8,
   parameter int START_UNITS      = 64,
   parameter int PERIOD_UNITS     = 192,
   parameter int LEAD_ON_UNITS    = 16,
   parameter int LEAD_OFF_UNITS   = 8,
   parameter int REP_OFF_UNITS    = 4,
   parameter int MARK_UNITS       = 1,
   parameter int ZERO_SPACE_UNITS = 1,
   parameter int ONE_SPACE_UNITS  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start,
   input  logic              key_held,
   input  logic              repeat_full,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CMD_W-1:0]  cmd,
   output logic              ir_out,
   output logic              lamp_n,
   output logic              done
);
   localparam int FRAME_BITS = ADDR_W + 2 * CMD_W;
   localparam int LONGEST_CODE = LEAD_ON_UNITS + LEAD_OFF_UNITS +
                                 FRAME_BITS * (MARK_UNITS + ONE_SPACE_UNITS) + MARK_UNITS;

   generate
      if (UNIT_TICKS < 2) begin : g_bad_unit
         $error("UNIT_TICKS must be at least 2");
      end
      if (CARRIER_HIGH < 1 || CARRIER_HIGH >= CARRIER_DIV) begin : g_bad_carrier
         $error("CARRIER_HIGH must lie between 1 and CARRIER_DIV-1");
      end
      if (LONGEST_CODE >= PERIOD_UNITS) begin : g_bad_period
         $error("PERIOD_UNITS must exceed the longest code");
      end
      if (START_UNITS < 1 || MARK_UNITS < 1 || ZERO_SPACE_UNITS < 1 ||
          LEAD_ON_UNITS < 1 || LEAD_OFF_UNITS < 1 || REP_OFF_UNITS < 1) begin : g_bad_seg
         $error("every segment must last at least one unit");
      end
   endgenerate

   logic restart;
   logic unit_end;
   logic code_active;
   logic burst;

   ir_tx_timebase #(
      .UNIT_TICKS(UNIT_TICKS)
   ) u_timebase (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .restart  (restart),
      .unit_end (unit_end)
   );

   ir_tx_sequencer #(
      .ADDR_W           (ADDR_W),
      .CMD_W            (CMD_W),
      .START_UNITS      (START_UNITS),
      .PERIOD_UNITS     (PERIOD_UNITS),
      .LEAD_ON_UNITS    (LEAD_ON_UNITS),
      .LEAD_OFF_UNITS   (LEAD_OFF_UNITS),
      .REP_OFF_UNITS    (REP_OFF_UNITS),
      .MARK_UNITS       (MARK_UNITS),
      .ZERO_SPACE_UNITS (ZERO_SPACE_UNITS),
      .ONE_SPACE_UNITS  (ONE_SPACE_UNITS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .key_held    (key_held),
      .repeat_full (repeat_full),
      .addr        (addr),
      .cmd         (cmd),
      .unit_end    (unit_end),
      .restart     (restart),
      .code_active (code_active),
      .burst       (burst),
      .done        (done)
   );

   ir_tx_carrier #(
      .CARRIER_DIV  (CARRIER_DIV),
      .CARRIER_HIGH (CARRIER_HIGH),
      .MODULATE     (MODULATE)
   ) u_carrier (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .burst  (burst),
      .ir_out (ir_out)
   );

   assign lamp_n = !code_active;
endmodule

// File: rtl/ir_frame_tx_chk.sv
module ir_frame_tx_chk #(
   parameter int CAR_HIGH = 4
) (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic ir_out,
   input logic lamp_n,
   input logic done
);
   logic [7:0] hi_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= '0;
      end else if (tick) begin
         if (ir_out) hi_run <= (hi_run == 8'hFF) ? hi_run : hi_run + 1'b1;
         else        hi_run <= '0;
      end
   end

   assert_carrier_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hi_run <= 8'(CAR_HIGH));

   assert_burst_in_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ir_out |-> !lamp_n);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lamp_n && !ir_out));

   assert_hold_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(ir_out) && $stable(lamp_n)));
endmodule

bind ir_frame_tx ir_frame_tx_chk #(.CAR_HIGH(CARRIER_HIGH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .ir_out (ir_out),
   .lamp_n (lamp_n),
   .done   (done)
);

// File: tb/test_ir_frame_tx.sv
module test_ir_frame_tx;
   localparam int U      = 24;
   localparam int DIV    = 12;
   localparam int CHI    = 4;
   localparam int CLO    = DIV - CHI;
   localparam int DLY    = 64 * U;
   localparam int PER    = 192 * U;
   localparam int MAXB   = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        start = 1'b0;
   logic        key_held = 1'b0;
   logic        repeat_full = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  cmd = '0;
   logic        ir_out;
   logic        lamp_n;
   logic        done;

   int checks = 0;
   int errors = 0;
   int tp = 1;
   int phase = 0;
   int tcnt = 0;
   int ccnt = 0;
   logic tick_was = 1'b0;
   bit finished = 1'b0;

   int bstart [MAXB];
   int bclk [MAXB];
   int nb = 0;
   int car_err = 0;
   int lamp_ticks = 0;
   int done_cnt = 0;
   int low_run = 1000;
   int hi_run = 0;
   logic prev_ir = 1'b0;

   int    exp_t [MAXB];
   string exp_tag [MAXB];
   int    ne;
   int    exp_lamp;

   ir_frame_tx #(.UNIT_TICKS(U)) i_ir_frame_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .key_held(key_held),
      .repeat_full(repeat_full), .addr(addr), .cmd(cmd),
      .ir_out(ir_out), .lamp_n(lamp_n), .done(done)
   );

   always #10 clk = ~clk;

   always @(negedge clk) begin
      phase = (phase + 1 >= tp) ? 0 : phase + 1;
      tick <= (phase == 0);
   end

   always @(posedge clk) begin
      ccnt <= ccnt + 1;
      if (tick) tcnt <= tcnt + 1;
      tick_was <= tick;
   end

   // waveform decoder: burst starts in ticks, carrier shape, lamp time, done pulses
   always @(negedge clk) begin
      if (rst_n && tick_was) begin
         if (ir_out) begin
            if (!prev_ir) begin
               if (low_run > CLO) begin
                  if (nb < MAXB) begin bstart[nb] = tcnt; bclk[nb] = ccnt; nb++; end
               end else if (low_run != CLO) car_err++;
               hi_run = 1;
            end else hi_run++;
            low_run = 0;
         end else begin
            if (prev_ir && hi_run != CHI) car_err++;
            low_run++;
         end
         prev_ir = ir_out;
         if (!lamp_n) lamp_ticks++;
      end
      if (rst_n && done) done_cnt++;
   end

   always @(posedge clk) begin
      if (ccnt > 190000 && !finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog R10 actual %0d expected %0d", ccnt, 190000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, expv);
      end
   endtask

   // expected burst starts, relative to strobe acceptance tick count ts
   task automatic build(input logic [15:0] a, input logic [7:0] c, input bit full,
                        input int ncodes, input int ts);
      logic [31:0] w;
      int t;
      w = {~c, c, a};
      ne = 0;
      exp_lamp = 0;
      for (int k = 0; k < ncodes; k++) begin
         t = ts + DLY + k * PER;
         if (k == 0 || full) begin
            exp_t[ne] = t; exp_tag[ne] = (k == 0) ? "R5 R3" : "R6 R8"; ne++;
            t += 24 * U;
            exp_lamp += 25 * U;
            for (int i = 0; i < 32; i++) begin
               exp_t[ne] = t; exp_tag[ne] = (i == 0) ? "R3 R1" : "R1 R2"; ne++;
               t += (w[i] ? 4 : 2) * U;
               exp_lamp += (w[i] ? 4 : 2) * U;
            end
            exp_t[ne] = t; exp_tag[ne] = "R2 R1"; ne++;
         end else begin
            exp_t[ne] = t; exp_tag[ne] = "R6 R7"; ne++;
            exp_t[ne] = t + 20 * U; exp_tag[ne] = "R7"; ne++;
            exp_lamp += 21 * U;
         end
      end
   endtask

   task automatic scenario(input logic [15:0] a, input logic [7:0] c, input bit full,
                           input int ncodes, input bit early_release, input int tick_per);
      int ts, cs, nb0, car0, lamp0, done0, lim, n;
      tp = tick_per;
      @(negedge clk);
      nb0 = nb; car0 = car_err; lamp0 = lamp_ticks; done0 = done_cnt;
      addr = a; cmd = c; repeat_full = full; key_held = 1'b1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ts = tcnt; cs = ccnt;
      // R11: inputs change after acceptance and must not matter
      addr = ~a; cmd = c ^ 8'h5A; repeat_full = ~full;
      if (early_release) begin
         while (tcnt < ts + 10 * U) @(negedge clk);
         key_held = 1'b0;
      end
      while (tcnt < ts + DLY + 40 * U) @(negedge clk);
      start = 1'b1;              // R11: strobe while busy
      @(negedge clk);
      start = 1'b0;
      if (!early_release) begin
         while (tcnt < ts + DLY + (ncodes - 1) * PER + 160 * U) @(negedge clk);
         key_held = 1'b0;
      end
      lim = 0;
      while (done_cnt == done0 && lim < 60000) begin @(negedge clk); lim++; end
      repeat (4 * tick_per + 4) @(negedge clk);
      build(a, c, full, ncodes, ts);
      n = nb - nb0;
      chk(n == ne, "R11 R8 burst count", n, ne);
      for (int i = 0; i < ne && i < n; i++)
         chk(bstart[nb0 + i] == exp_t[i], exp_tag[i], bstart[nb0 + i] - ts, exp_t[i] - ts);
      chk(car_err == car0, "R4 carrier shape errors", car_err - car0, 0);
      chk(lamp_ticks - lamp0 == exp_lamp, "R9 lamp low ticks", lamp_ticks - lamp0, exp_lamp);
      chk(done_cnt - done0 == 1, "R10 done pulses", done_cnt - done0, 1);
      chk(lamp_n == 1'b1 && ir_out == 1'b0, "R10 idle after done", {lamp_n, ir_out}, 2);
      if (tick_per > 1 && n > 0) begin
         chk((bclk[nb0] - cs) >= 64 * U * tick_per - tick_per + 1 &&
             (bclk[nb0] - cs) <= 64 * U * tick_per,
             "R12 holdoff in clocks", bclk[nb0] - cs, 64 * U * tick_per);
      end
   endtask

   initial begin
      logic [15:0] ra;
      logic [7:0]  rc;
      bit          rf;
      int          rn;
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      // R13: reset state
      chk(ir_out == 1'b0, "R13 ir_out in reset", ir_out, 0);
      chk(lamp_n == 1'b1, "R13 lamp_n in reset", lamp_n, 1);
      chk(done == 1'b0, "R13 done in reset", done, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(ir_out == 1'b0 && lamp_n == 1'b1 && done == 1'b0, "R13 idle after reset",
          {ir_out, lamp_n, done}, 2);

      scenario(16'h3C5A, 8'h00, 1'b0, 1, 1'b1, 1);   // R5 release in holdoff
      scenario(16'hFFFF, 8'hFF, 1'b0, 3, 1'b0, 1);   // R7 one-shot repeats
      scenario(16'h1234, 8'h81, 1'b1, 2, 1'b0, 1);   // R8 full repeats
      scenario(16'hFFFF, 8'hFF, 1'b1, 1, 1'b1, 1);   // longest frame, release early
      scenario(16'h00A7, 8'h4C, 1'b0, 2, 1'b0, 3);   // R12 sparse ticks
      for (int s = 0; s < 3; s++) begin
         ra = 16'($urandom);
         rc = 8'($urandom);
         rf = 1'($urandom);
         rn = 1 + int'($urandom % 2);
         scenario(ra, rc, rf, rn, (rn == 1) ? 1'($urandom) : 1'b0, 1);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule